// File: doc/BRIEF.md
# Dual Word FIFO with Flush and Request Triggers

This block sits between a register bus and an I2C packet engine. It holds two queues of 32-bit words. Software fills the transmit queue and the engine drains it one word at a time. The engine fills the receive queue and software drains it. Each word carries up to four bus bytes.

A control word sets a request threshold for each queue and has a flush bit for each queue. A flush bit clears itself once its flush has run. A status word reports how many transmit slots are free and how many receive words are held.

The transmit request is raised while free space is above the transmit threshold. The receive request is raised while the fill is above the receive threshold. Both requests are held low while their queue is being flushed. A write to a full transmit queue and a read from an empty receive queue each produce a one-cycle event pulse.

Top module: `i2c_word_fifo_pair`

## Requirements
- R1: After a synchronous reset:
  - the control word reads 0x00 and the status word reads 0x80 (8 free transmit slots, 0 receive words);
  - `tx_req` is 1; `rx_req`, `tx_valid`, `rx_full`, `tx_ovf` and `rx_unf` are 0.
- R2: Register select 0 is the control word, laid out as follows:
  - bit 0 is the receive flush and bit 1 is the transmit flush;
  - bits 4:2 hold the receive trigger and bits 7:5 hold the transmit trigger;
  - bits 31:8 read as 0;
  - writing 0xFFFFFFFC reads back 0x000000FC.
- R3: A register write to select 2 appends a word to the transmit queue. `tx_word` shows the oldest word while `tx_valid` is 1. A `tx_take` pulse removes that word. `tx_take` on an empty queue has no effect.
- R4: Register select 1 is the status word: receive word count in bits 3:0, transmit free slots in bits 7:4. It changes on the clock edge that pushes or pops a word.
- R5: A write to select 2 while the transmit queue holds 8 words drops the word, leaves the queue contents unchanged, and pulses `tx_ovf` high for the one cycle after that edge.
- R6: A read of select 3 while the receive queue is empty returns 0. It leaves the count at 0 and pulses `rx_unf` high for the one cycle after that edge.
- R7: An `rx_put` pulse appends `rx_word` to the receive queue. A read of select 3 returns the oldest receive word and removes it on that clock edge.
- R8: With 8 receive words held, `rx_full` is 1 and a further `rx_put` is ignored.
- R9: `tx_req` is 1 exactly when the number of free transmit slots is greater than the transmit trigger and no transmit flush is pending.
- R10: `rx_req` is 1 exactly when the receive word count is greater than the receive trigger and no receive flush is pending.
- R11: Writing control bit 1 as 1 has these effects:
  - the bit reads back 1 for one cycle, with `tx_req` held at 0;
  - on the next edge the transmit queue empties and the bit reads 0;
  - the receive queue is left unchanged.
- R12: Writing control bit 0 as 1 has these effects:
  - the bit reads back 1 for one cycle, with `rx_req` held at 0;
  - on the next edge the receive queue empties and the bit reads 0.
- R13: A push and a pop on the same edge, into a queue that is neither empty nor full, advance the head and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at select 3) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from select) |
| tx_word | output | 32 | Oldest transmit word |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Engine consumes the oldest transmit word |
| rx_word | input | 32 | Word from the engine |
| rx_put | input | 1 | Engine appends `rx_word` |
| rx_full | output | 1 | Receive queue holds 8 words |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | One-cycle transmit overflow event |
| rx_unf | output | 1 | One-cycle receive underflow event |

## Verification
The bench pushes each queue past full and reads the empty receive queue.
- A design that let the extra word in would corrupt the transmit order.
- A design that dropped the event pulse would leave `tx_ovf` or `rx_unf` low.

Trigger levels are set so that the requests sit one slot either side of the threshold. An off-by-one comparison shows up as a request one word early or late.

Each flush is sampled in the cycle while it is pending and in the cycle after it completes.
- A flush bit that never clears, or a request that is not gated, gives a wrong readback.
- A flush that disturbs the other queue gives a wrong status word.

Simultaneous push and pop is checked against a count that must not move.

// File: rtl/i2cwf_pkg.sv
package i2cwf_pkg;

    localparam int WORD_W  = 32;
    localparam int TRIG_W  = 3;
    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_TXDAT = 2'd2,
        SEL_RXDAT = 2'd3
    } reg_sel_e;

    // Packed MSB first: tx_trig [7:5], rx_trig [4:2], tx_flush [1], rx_flush [0]
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        logic              tx_flush;
        logic              rx_flush;
    } ctrl_t;

    // tx_free [7:4], rx_fill [3:0]
    typedef struct packed {
        logic [FIELD_W-1:0] tx_free;
        logic [FIELD_W-1:0] rx_fill;
    } stat_t;

    // A threshold t is met once at least t+1 units are available.
    function automatic logic trig_met(logic [FIELD_W-1:0] level,
                                      logic [TRIG_W-1:0]  trig);
        return level > {{(FIELD_W-TRIG_W){1'b0}}, trig};
    endfunction

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= bump(wp);
            if (pop_ok)  rp <= bump(rp);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: count stays within the storage depth
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R11 / R12: a pending flush leaves the queue empty on the next cycle
    a_r11_r12_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    // R13: push and pop together on a partly filled queue keep the count
    a_r13_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !flush && count != '0 && count != CNT_W'(DEPTH))
        |=> $stable(count));

endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
    import i2cwf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    output ctrl_t      cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_ctrl) begin
            cfg <= ctrl_t'(wdata);
        end else begin
            cfg.tx_flush <= 1'b0;
            cfg.rx_flush <= 1'b0;
        end
    end

    // R11: transmit flush bit clears itself after one cycle
    a_r11_tx_flush_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg.tx_flush && !(wr_ctrl && wdata[1])) |=> !cfg.tx_flush);

    // R12: receive flush bit clears itself after one cycle
    a_r12_rx_flush_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg.rx_flush && !(wr_ctrl && wdata[0])) |=> !cfg.rx_flush);

endmodule

// File: rtl/wfifo_req.sv
module wfifo_req
    import i2cwf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter bit IS_TX = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic [TRIG_W-1:0] trig,
    input  logic              busy,
    output logic              req
);

    logic [CNT_W-1:0] level;

    generate
        if (IS_TX) begin : g_free
            assign level = CNT_W'(DEPTH) - count;
        end else begin : g_fill
            assign level = count;
        end
    endgenerate

    assign req = !busy && trig_met(FIELD_W'(level), trig);

    // R11 / R12: a pending flush holds the request low
    a_r11_r12_req_off_in_flush: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req);

endmodule

// File: rtl/i2c_word_fifo_pair.sv
module i2c_word_fifo_pair
    import i2cwf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_put,
    output logic              rx_full,
    output logic              tx_req,
    output logic              rx_req,
    output logic              tx_ovf,
    output logic              rx_unf
);

    reg_sel_e          sel;
    ctrl_t             cfg;
    stat_t             stat;
    logic              wr_ctrl, tx_push, rx_pop;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_empty;
    logic [WORD_W-1:0] rx_head;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
    assign tx_push = reg_wr && (sel == SEL_TXDAT);
    assign rx_pop  = reg_rd && (sel == SEL_RXDAT);

    wfifo_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (reg_wdata[7:0]),
        .cfg     (cfg)
    );

    wfifo_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg.tx_flush),
        .push      (tx_push),
        .push_data (reg_wdata),
        .pop       (tx_take),
        .head      (tx_word),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    wfifo_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg.rx_flush),
        .push      (rx_put),
        .push_data (rx_word),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    wfifo_req #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_txreq (
        .clk   (clk),
        .rst   (rst),
        .count (tx_cnt),
        .trig  (cfg.tx_trig),
        .busy  (cfg.tx_flush),
        .req   (tx_req)
    );

    wfifo_req #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rxreq (
        .clk   (clk),
        .rst   (rst),
        .count (rx_cnt),
        .trig  (cfg.rx_trig),
        .busy  (cfg.rx_flush),
        .req   (rx_req)
    );

    assign tx_valid     = !tx_empty;
    assign stat.tx_free = FIELD_W'(CNT_W'(DEPTH) - tx_cnt);
    assign stat.rx_fill = FIELD_W'(rx_cnt);

    always_comb begin
        case (sel)
            SEL_CTRL:  reg_rdata = {{(WORD_W-8){1'b0}}, cfg};
            SEL_STAT:  reg_rdata = {{(WORD_W-8){1'b0}}, stat};
            SEL_RXDAT: reg_rdata = rx_empty ? '0 : rx_head;
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            tx_ovf <= tx_push && tx_full;
            rx_unf <= rx_pop && rx_empty;
        end
    end

    // R5: a write into a full transmit queue yields an overflow pulse
    a_r5_ovf_pulse: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && tx_cnt == CNT_W'(DEPTH)) |=> tx_ovf);

    // R6: a read from an empty receive queue yields an underflow pulse
    a_r6_unf_pulse: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd3 && rx_cnt == '0) |=> rx_unf);

    // R8: a full receive queue does not grow
    a_r8_rx_no_grow: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_pop) |=> rx_full);

endmodule

// File: tb/i2c_word_fifo_pair_tb_top.sv
module i2c_word_fifo_pair_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, tx_word, rx_word = '0;
    logic        tx_valid, tx_take = 1'b0, rx_put = 1'b0, rx_full;
    logic        tx_req, rx_req, tx_ovf, rx_unf;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    i2c_word_fifo_pair dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_word(rx_word), .rx_put(rx_put), .rx_full(rx_full),
        .tx_req(tx_req), .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rx_read(output logic [31:0] d);
        reg_addr = 2'd3; reg_rd = 1'b1; #1; d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic take(output logic [31:0] w);
        #1; w = tx_word; tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic put(logic [31:0] w);
        rx_word = w; rx_put = 1'b1;
        @(negedge clk);
        rx_put = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(2'd0, d); chk("R1 ctrl", d, 32'h0);
        peek(2'd1, d); chk("R1 status", d, 32'h80);
        chk("R1 flags", {tx_req, rx_req, tx_valid, rx_full, tx_ovf, rx_unf}, 32'h20);
    endtask

    task automatic t_ctrl_rw();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFC);
        peek(2'd0, d); chk("R2 readback", d, 32'hFC);
        wr(2'd0, 32'h0);
        peek(2'd0, d); chk("R2 clear", d, 32'h0);
    endtask

    task automatic t_tx_order();
        logic [31:0] d, w;
        wr(2'd2, 32'hA000_0001); wr(2'd2, 32'hB000_0002); wr(2'd2, 32'hC000_0003);
        peek(2'd1, d); chk("R4 tx free 5", d, 32'h50);
        chk("R3 valid", {31'b0, tx_valid}, 32'h1);
        take(w); chk("R3 first", w, 32'hA000_0001);
        peek(2'd1, d); chk("R4 tx free 6", d, 32'h60);
        take(w); chk("R3 second", w, 32'hB000_0002);
        take(w); chk("R3 third", w, 32'hC000_0003);
        chk("R3 empty", {31'b0, tx_valid}, 32'h0);
        take(w);
        peek(2'd1, d); chk("R3 take on empty ignored", d, 32'h80);
    endtask

    task automatic t_tx_overflow();
        logic [31:0] d, w;
        for (int i = 0; i < 8; i++) wr(2'd2, 32'h1100_0000 + i);
        peek(2'd1, d); chk("R4 tx full", d, 32'h00);
        chk("R5 no ovf yet", {31'b0, tx_ovf}, 32'h0);
        wr(2'd2, 32'hDEAD_BEEF);
        chk("R5 ovf pulse", {31'b0, tx_ovf}, 32'h1);
        @(negedge clk);
        chk("R5 ovf one cycle", {31'b0, tx_ovf}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            take(w); chk("R5 contents kept", w, 32'h1100_0000 + i);
        end
        peek(2'd1, d); chk("R5 drained", d, 32'h80);
    endtask

    task automatic t_tx_trig_flush();
        logic [31:0] d;
        wr(2'd0, 32'h80);
        chk("R9 req at free 8", {31'b0, tx_req}, 32'h1);
        for (int i = 0; i < 3; i++) wr(2'd2, 32'h2200_0000 + i);
        chk("R9 req at free 5", {31'b0, tx_req}, 32'h1);
        wr(2'd2, 32'h2200_0003);
        chk("R9 no req at free 4", {31'b0, tx_req}, 32'h0);
        put(32'h5500_0001); put(32'h5500_0002);
        wr(2'd2, 32'h2200_0004);
        wr(2'd0, 32'h82);
        peek(2'd0, d); chk("R11 flush bit pending", d, 32'h82);
        chk("R11 req low in flush", {31'b0, tx_req}, 32'h0);
        @(negedge clk);
        peek(2'd0, d); chk("R11 flush bit cleared", d, 32'h80);
        peek(2'd1, d); chk("R11 tx empty rx kept", d, 32'h82);
        chk("R11 req back", {31'b0, tx_req}, 32'h1);
        chk("R11 no valid", {31'b0, tx_valid}, 32'h0);
        rx_read(d); chk("R11 rx word kept", d, 32'h5500_0001);
        rx_read(d); chk("R11 rx word kept", d, 32'h5500_0002);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_rx_order_underflow();
        logic [31:0] d;
        put(32'h3300_0001); put(32'h3300_0002); put(32'h3300_0003);
        peek(2'd1, d); chk("R4 rx fill 3", d, 32'h83);
        rx_read(d); chk("R7 first", d, 32'h3300_0001);
        peek(2'd1, d); chk("R4 rx fill 2", d, 32'h82);
        rx_read(d); chk("R7 second", d, 32'h3300_0002);
        rx_read(d); chk("R7 third", d, 32'h3300_0003);
        chk("R6 no unf yet", {31'b0, rx_unf}, 32'h0);
        rx_read(d); chk("R6 empty read data", d, 32'h0);
        chk("R6 unf pulse", {31'b0, rx_unf}, 32'h1);
        peek(2'd1, d); chk("R6 count stays", d, 32'h80);
        @(negedge clk);
        chk("R6 unf one cycle", {31'b0, rx_unf}, 32'h0);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        for (int i = 0; i < 9; i++) put(32'h4400_0000 + i);
        chk("R8 rx_full", {31'b0, rx_full}, 32'h1);
        peek(2'd1, d); chk("R8 fill 8", d, 32'h88);
        for (int i = 0; i < 8; i++) begin
            rx_read(d); chk("R8 order", d, 32'h4400_0000 + i);
        end
        peek(2'd1, d); chk("R8 ninth dropped", d, 32'h80);
    endtask

    task automatic t_rx_trig_flush();
        logic [31:0] d;
        wr(2'd0, 32'h08);
        put(32'h6600_0001); put(32'h6600_0002);
        chk("R10 no req at 2", {31'b0, rx_req}, 32'h0);
        put(32'h6600_0003);
        chk("R10 req at 3", {31'b0, rx_req}, 32'h1);
        wr(2'd0, 32'h09);
        peek(2'd0, d); chk("R12 flush pending", d, 32'h09);
        chk("R12 req low in flush", {31'b0, rx_req}, 32'h0);
        @(negedge clk);
        peek(2'd0, d); chk("R12 flush cleared", d, 32'h08);
        peek(2'd1, d); chk("R12 rx empty", d, 32'h80);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_simul();
        logic [31:0] d, w;
        wr(2'd2, 32'h7700_0001); wr(2'd2, 32'h7700_0002);
        reg_addr = 2'd2; reg_wdata = 32'h7700_0003; reg_wr = 1'b1; tx_take = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_take = 1'b0;
        peek(2'd1, d); chk("R13 tx count held", d, 32'h60);
        take(w); chk("R13 tx head advanced", w, 32'h7700_0002);
        take(w); chk("R13 tx pushed word", w, 32'h7700_0003);
        put(32'h8800_0001); put(32'h8800_0002);
        rx_word = 32'h8800_0003; rx_put = 1'b1;
        reg_addr = 2'd3; reg_rd = 1'b1; #1; d = reg_rdata;
        chk("R13 rx read oldest", d, 32'h8800_0001);
        @(negedge clk);
        rx_put = 1'b0; reg_rd = 1'b0;
        peek(2'd1, d); chk("R13 rx count held", d, 32'h82);
        rx_read(d); chk("R13 rx order", d, 32'h8800_0002);
        rx_read(d); chk("R13 rx order", d, 32'h8800_0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_rw();
        t_tx_order();
        t_tx_overflow();
        t_tx_trig_flush();
        t_rx_order_underflow();
        t_rx_full();
        t_rx_trig_flush();
        t_simul();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule